// File: doc/BRIEF.md
# Scatter-Gather Descriptor List Walker

This block is the front end of a DMA path that consumes a table of fixed-size descriptors held in memory. Software places the table at some base address and pulses `start`. The walker then reads the table entry by entry through a single-word request/response memory port. For each entry it forms a segment command (buffer address plus byte count) and hands it to a downstream data mover through a valid/ready handshake.

Each entry is two 32-bit little-endian words, eight bytes in all. The first word is the length word: its low 28 bits carry the byte count and its top bit marks the final entry. The second word is the buffer address, of which only bits 30:0 are used. The walk ends in one of three ways: after the entry that carries the final flag, after `MAX_ENTRIES` entries with no final flag (an error), or on a memory error response (also an error). Every walk closes with a one-cycle `done` pulse. At that point the walker reports the number of segments accepted and the sum of their byte counts.

Top module: `sg_walker`

## Requirements
- R1: Entry n is read as two single-word requests, the length word at base+8n and then the address word at base+8n+4. At most one request is outstanding, and no request is issued while a segment command is offered. A request holds its address until `mem_req_ready` accepts it.
- R2: `seg_len` equals bits 27:0 of the entry's length word; bits 30:28 are discarded.
- R3: `seg_addr` equals the entry's address word with bit 31 forced to zero.
- R4: While `seg_valid` is high and `seg_ready` is low, `seg_valid`, `seg_addr` and `seg_len` hold steady.
- R5: When bit 31 of an entry's length word is set, no further memory request follows the acceptance of that entry's segment. `done` is high for exactly the one cycle after that acceptance, and `error` is low.
- R6: If `MAX_ENTRIES` segments are accepted and none carried the final flag, the walk ends at once with `done` and `error` both high. No further entry is read.
- R7: A memory response with `mem_rsp_err` high ends the walk with `done` and `error` both high. No further request and no segment follows. `done_count` then equals the segments accepted before the failing read.
- R8: `done_count` gives the number of segments accepted and `done_bytes` gives the sum of their `seg_len`. Both are valid with `done` and keep their values until the next accepted `start`.
- R9: `start` is ignored while `busy` is high. A second start during a walk changes neither the segments nor the number of `done` pulses.
- R10: After reset the block is idle: `busy`, `mem_req_valid`, `seg_valid`, `done` and `error` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk at `base_addr` (taken only when idle) |
| base_addr | input | 32 | Byte address of descriptor 0 |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read data word (little-endian assembled) |
| mem_rsp_err | input | 1 | Read response carries an error |
| seg_valid | output | 1 | Segment command valid |
| seg_ready | input | 1 | Data mover accepts the segment |
| seg_addr | output | 32 | Segment buffer address, bit 31 zero |
| seg_len | output | 28 | Segment byte count |
| done | output | 1 | One-cycle end-of-walk pulse |
| error | output | 1 | High with `done` when the walk ended abnormally |
| done_count | output | $clog2(MAX_ENTRIES+1) | Segments accepted in the last walk |
| done_bytes | output | 28+$clog2(MAX_ENTRIES+1) | Total bytes of the accepted segments |

## Verification
The assertions assume that the memory returns exactly one response for each accepted request, and only after it has been accepted. They also assume that `base_addr` is word aligned. The bench's memory model answers one cycle after each accepted request and never otherwise. All bases it programs are multiples of eight. Ready signals on both the memory and segment sides are swept across always-ready, pseudo-random and mostly-stalled patterns.

// File: rtl/sg_walker.sv
module sg_walker #(
  parameter int MAX_ENTRIES = 16,
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1),
  localparam int SUM_W = 28 + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      base_addr,
  output logic             busy,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [31:0]      mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  input  logic             mem_rsp_err,
  output logic             seg_valid,
  input  logic             seg_ready,
  output logic [31:0]      seg_addr,
  output logic [27:0]      seg_len,
  output logic             done,
  output logic             error,
  output logic [CNT_W-1:0] done_count,
  output logic [SUM_W-1:0] done_bytes
);

  typedef enum logic [2:0] {
    S_IDLE, S_REQ_LEN, S_WAIT_LEN, S_REQ_ADR, S_WAIT_ADR, S_SEG, S_FIN
  } state_t;

  state_t           st;
  logic [31:0]      base_q;
  logic [CNT_W-1:0] idx_q;
  logic [27:0]      len_q;
  logic             last_q;
  logic [30:0]      addr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] sum_q;
  logic             err_q;

  assign busy          = (st != S_IDLE);
  assign mem_req_valid = (st == S_REQ_LEN) || (st == S_REQ_ADR);
  assign mem_req_addr  = base_q + (32'(idx_q) << 3) + ((st == S_REQ_ADR) ? 32'd4 : 32'd0);
  assign seg_valid     = (st == S_SEG);
  assign seg_addr      = {1'b0, addr_q};
  assign seg_len       = len_q;
  assign done          = (st == S_FIN);
  assign error         = done && err_q;
  assign done_count    = cnt_q;
  assign done_bytes    = sum_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      base_q <= '0;
      idx_q  <= '0;
      len_q  <= '0;
      last_q <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
      sum_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (start) begin
            base_q <= base_addr;
            idx_q  <= '0;
            cnt_q  <= '0;
            sum_q  <= '0;
            err_q  <= 1'b0;
            st     <= S_REQ_LEN;
          end
        S_REQ_LEN:
          if (mem_req_ready) st <= S_WAIT_LEN;
        S_WAIT_LEN:
          if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              err_q <= 1'b1;
              st    <= S_FIN;
            end else begin
              len_q  <= mem_rsp_data[27:0];
              last_q <= mem_rsp_data[31];
              st     <= S_REQ_ADR;
            end
          end
        S_REQ_ADR:
          if (mem_req_ready) st <= S_WAIT_ADR;
        S_WAIT_ADR:
          if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              err_q <= 1'b1;
              st    <= S_FIN;
            end else begin
              addr_q <= mem_rsp_data[30:0];
              st     <= S_SEG;
            end
          end
        S_SEG:
          if (seg_ready) begin
            cnt_q <= cnt_q + 1'b1;
            sum_q <= sum_q + SUM_W'(len_q);
            if (last_q) begin
              st <= S_FIN;
            end else if (idx_q == CNT_W'(MAX_ENTRIES - 1)) begin
              err_q <= 1'b1;
              st    <= S_FIN;
            end else begin
              idx_q <= idx_q + 1'b1;
              st    <= S_REQ_LEN;
            end
          end
        default:
          st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sg_walker_chk.sv
module sg_walker_chk #(
  parameter int MAX_ENTRIES = 16,
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [31:0]      mem_req_addr,
  input logic             seg_valid,
  input logic             seg_ready,
  input logic [31:0]      seg_addr,
  input logic [27:0]      seg_len,
  input logic             done,
  input logic             error,
  input logic [CNT_W-1:0] done_count
);

  a_r1_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r1_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && seg_valid));

  a_r4_seg_held: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len));

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_error_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> done_count <= CNT_W'(MAX_ENTRIES));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !seg_valid && !done);

endmodule

bind sg_walker sg_walker_chk #(.MAX_ENTRIES(MAX_ENTRIES)) u_chk (.*);

// File: tb/tb_sg_walker.sv
module tb_sg_walker;
  localparam int MAXE  = 4;
  localparam int CNT_W = $clog2(MAXE + 1);
  localparam int SUM_W = 28 + CNT_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] base_addr = '0;
  logic busy, mem_req_valid, mem_req_ready, mem_rsp_valid, mem_rsp_err;
  logic [31:0] mem_req_addr, mem_rsp_data, seg_addr;
  logic seg_valid, seg_ready, done, error;
  logic [27:0] seg_len;
  logic [CNT_W-1:0] done_count;
  logic [SUM_W-1:0] done_bytes;

  always #2.5 clk = ~clk;

  sg_walker #(.MAX_ENTRIES(MAXE)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
    .done(done), .error(error), .done_count(done_count), .done_bytes(done_bytes));

  int tests = 0, fails = 0;
  logic [31:0] mem [64];
  int rmode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] walk_base = '0;
  logic [31:0] err_addr = '0;
  bit err_en = 0;
  int nreq = 0, addr_bad = 0, nseg = 0, ndone = 0, stall_bad = 0;
  logic [31:0] got_addr [8];
  logic [27:0] got_len [8];
  logic [CNT_W-1:0] d_cnt;
  logic [SUM_W-1:0] d_bytes;
  logic d_err;
  bit prev_stall = 0;
  logic [31:0] prev_a;
  logic [27:0] prev_l;

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_req_ready <= (rmode == 0) ? 1'b1 : (rmode == 1) ? lfsr[0] : (lfsr[3] & lfsr[5]);
    seg_ready     <= (rmode == 0) ? 1'b1 : (rmode == 1) ? lfsr[7] : (lfsr[9] & lfsr[2]);
    mem_rsp_valid <= 1'b0;
    mem_rsp_err   <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_addr != walk_base + 32'(4 * nreq)) addr_bad <= addr_bad + 1;
      nreq <= nreq + 1;
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem[mem_req_addr[7:2]];
      mem_rsp_err   <= err_en && (mem_req_addr == err_addr);
    end
    if (prev_stall && (!seg_valid || seg_addr != prev_a || seg_len != prev_l))
      stall_bad <= stall_bad + 1;
    prev_stall <= seg_valid && !seg_ready;
    prev_a <= seg_addr;
    prev_l <= seg_len;
    if (seg_valid && seg_ready) begin
      if (nseg < 8) begin
        got_addr[nseg] <= seg_addr;
        got_len[nseg]  <= seg_len;
      end
      nseg <= nseg + 1;
    end
    if (done) begin
      ndone   <= ndone + 1;
      d_cnt   <= done_count;
      d_bytes <= done_bytes;
      d_err   <= error;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] len_word(int t, int i, bit last);
    return {last, 3'b101, 28'(i * 4099 + t * 77 + 3)};
  endfunction

  function automatic logic [31:0] adr_word(int t, int i);
    return 32'hC000_0000 + 32'(i * 64 + t);
  endfunction

  task automatic pulse_start(input logic [31:0] b);
    @(negedge clk);
    base_addr = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int tmo = 0;
    while (ndone == 0 && tmo < 3000) begin
      @(negedge clk);
      tmo++;
    end
    chk(ndone != 0, "R5", "watchdog: walk finished", ndone, 1);
  endtask

  task automatic run(input int t, input int last_at, input int err_w, input int rm,
                     input bit restart);
    int stop, exp_cnt, exp_reads;
    bit exp_err;
    string tag;
    logic [SUM_W-1:0] exp_bytes;
    for (int k = 0; k < 64; k++) mem[k] = 32'hDEAD_0000 | 32'(k);
    walk_base = 32'h2000_0000 | 32'(t * 8);
    for (int i = 0; i <= MAXE; i++) begin
      mem[(t * 2) + 2 * i]     = len_word(t, i, (i + 1) == last_at);
      mem[(t * 2) + 2 * i + 1] = adr_word(t, i);
    end
    stop      = (last_at > 0) ? last_at : MAXE;
    exp_err   = (last_at == 0) || (err_w >= 0);
    exp_cnt   = (err_w >= 0) ? err_w / 2 : stop;
    exp_reads = (err_w >= 0) ? err_w + 1 : 2 * stop;
    tag       = (err_w >= 0) ? "R7" : (last_at == 0) ? "R6" : "R5";
    err_en    = (err_w >= 0);
    err_addr  = walk_base + 32'(4 * err_w);
    @(negedge clk);
    rmode = rm;
    nreq = 0; addr_bad = 0; nseg = 0; ndone = 0; stall_bad = 0;
    pulse_start(walk_base);
    if (restart) begin
      repeat (4) @(negedge clk);
      pulse_start(32'h2000_0000 | 32'((t + 3) * 8));
    end
    wait_done();
    repeat (12) @(negedge clk);
    chk(ndone == 1, restart ? "R9" : tag, "done pulses", ndone, 1);
    chk(nseg == exp_cnt, tag, "segments accepted", nseg, exp_cnt);
    chk(d_err == exp_err, tag, "error with done", d_err, exp_err);
    chk(nreq == exp_reads, tag, "memory reads", nreq, exp_reads);
    chk(addr_bad == 0, "R1", "request address order", addr_bad, 0);
    chk(stall_bad == 0, "R4", "segment held under stall", stall_bad, 0);
    exp_bytes = '0;
    for (int i = 0; i < exp_cnt && i < nseg; i++) begin
      logic [31:0] ea;
      logic [27:0] el;
      ea = adr_word(t, i) & 32'h7FFF_FFFF;
      el = len_word(t, i, 1'b0) & 32'h0FFF_FFFF;
      exp_bytes += SUM_W'(el);
      chk(got_len[i] == el, "R2", "segment length", got_len[i], el);
      chk(got_addr[i] == ea, restart ? "R9" : "R3", "segment address", got_addr[i], ea);
    end
    chk(d_cnt == CNT_W'(exp_cnt), "R8", "done_count", d_cnt, exp_cnt);
    chk(d_bytes == exp_bytes, "R8", "done_bytes", d_bytes, exp_bytes);
    chk(done_count == CNT_W'(exp_cnt) && done_bytes == exp_bytes && !busy, "R8",
        "totals held while idle", done_bytes, exp_bytes);
  endtask

  initial begin
    int wd = 0;
    fork
      begin
        while (wd < 190000) begin
          @(posedge clk);
          wd++;
        end
        chk(1'b0, "R10", "global watchdog", wd, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req_valid && !seg_valid && !done && !error, "R10",
        "idle during reset", {busy, mem_req_valid, seg_valid, done, error}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req_valid && !seg_valid && !done, "R10", "idle after reset",
        {busy, mem_req_valid, seg_valid, done}, 0);
    for (int rm = 0; rm < 3; rm++)
      for (int la = 1; la <= MAXE; la++)
        run(la + rm * 4, la, -1, rm, 1'b0);
    for (int rm = 0; rm < 3; rm++)
      run(rm + 1, 0, -1, rm, 1'b0);
    for (int w = 0; w < 2 * MAXE; w++)
      run(w, 0, w, 1 + (w % 2), 1'b0);
    run(5, 3, -1, 2, 1'b1);
    run(2, 0, -1, 1, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule